// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Serial Register Interface

This block is the digital control front end of a four-channel, 16-bit converter. A host writes one channel at a time over a three-wire serial port made of an active-low select, a serial clock and a data line. Each word is an 18-bit frame: a 2-bit channel address followed by 16 data bits, most significant bit first. When the select line is released, the data lands in the input register of the addressed channel. A shared, active-low, level-sensitive load strobe then copies all four input registers into the four output registers at once. This lets several channels change on the same instant.

The serial clock, select, load strobe and data are brought into a faster system clock through two-flop synchronisers, and serial clock edges are detected there. The load strobe also acts asynchronously: while it is low, the outputs show the input registers at once. An asynchronous active-low reset loads every register with zero or half scale, as chosen by a select input. A power-on reset clears everything to zero. A serial output repeats each input bit 19 clock pulses later, so several devices can share one chain.

The serial engine is a three-state machine:
- `ST_IDLE`: select is high.
- `ST_SHIFT`: select is low and bits are being shifted.
- `ST_COMMIT`: a one-cycle input-register write.

Its transitions are:
- T_SELECT: `ST_IDLE` to `ST_SHIFT` when select falls.
- T_RELEASE: `ST_SHIFT` to `ST_COMMIT` when select rises.
- T_RESELECT: `ST_COMMIT` to `ST_SHIFT` when select is already low again.
- T_DONE: `ST_COMMIT` to `ST_IDLE` otherwise.

Top module: `quad_dbuf_serial_if`

## Requirements
- R1: A frame is shifted most significant bit first: address bit 1, address bit 0, then data bit 15 down to data bit 0. Address value k (0 to 3) selects channel k, which appears on `dac_q[16*k+15:16*k]`.
- R2: Serial clock rising edges while `cs_n` is high shift nothing. They leave `sdo`, the strobe and every register unchanged.
- R3: When `cs_n` rises, `wr_stb` pulses for exactly one system cycle with `wr_addr` equal to the frame address. Only the addressed input register takes the 16 data bits.
- R4: While `ld_n` stays high, `dac_q` holds its values and input-register writes do not reach it.
- R5: While `ld_n` is low, every channel of `dac_q` shows its input register immediately. It keeps following writes made during that time, and the value is retained after `ld_n` returns high.
- R6: While `rs_n` is low, every input and output register holds 0x0000 if `rs_mid` is 0, or 0x8000 if `rs_mid` is 1. The serial shift chain is cleared.
- R7: After power-on reset (`por_n` low), all channels read 0x0000 and `sdo` is 0.
- R8: `sdo` presents the bit that was sampled on `sdi` 19 shifting clock pulses earlier. It is 0 until 19 pulses have occurred since reset.
- R9: If a frame has other than 18 bits, the write uses the 18 most recently shifted bits. Bits shifted before the last reset count as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| cs_n | input | 1 | Serial select, active low |
| sdi | input | 1 | Serial data in |
| ld_n | input | 1 | Global load strobe, active low, level sensitive |
| rs_n | input | 1 | Reset to the selected code, active low, asynchronous |
| rs_mid | input | 1 | Reset code select: 0 gives zero scale, 1 gives half scale |
| sdo | output | 1 | Serial data out for daisy chaining |
| dac_q | output | 64 | Four 16-bit output register values, channel 0 in the low bits |
| wr_stb | output | 1 | One-cycle pulse on each input-register write |
| wr_addr | output | 2 | Channel written while `wr_stb` is high |

## Verification
A serial clock edge is seen three system cycles after it happens: two synchroniser flops and one edge-detect flop. So a shifted bit reaches `sdo` about four cycles after the rising edge. A rise of `cs_n` produces `wr_stb` four cycles later, and the input register changes one cycle after that. The bench holds every serial phase for six system cycles, waits eight after releasing select, and samples on the falling system clock edge, well past each due cycle. The load strobe's effect on `dac_q` is immediate, but the retained copy needs three cycles. The bench therefore holds `ld_n` low for at least six cycles before releasing it and checking the held value.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } ser_state_e;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/qdac_serial_fsm.sv
module qdac_serial_fsm
    import qdac_pkg::*;
#(
    parameter  int ADDR_W  = 2,
    parameter  int DATA_W  = 16,
    localparam int FRAME_W = ADDR_W + DATA_W,
    localparam int CHAIN_W = FRAME_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_s,
    input  logic              sdi_s,
    output logic              sdo,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic               sclk_d;
    logic               shift_en;
    logic [CHAIN_W-1:0] chain;
    ser_state_e         state;
    ser_state_e         state_nx;

    // A rising serial clock edge counts only while select is low.
    assign shift_en = !cs_s && sclk_s && !sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            chain  <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (shift_en) begin
                chain <= {chain[CHAIN_W-2:0], sdi_s};
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!cs_s) state_nx = ST_SHIFT;        // T_SELECT
            end
            ST_SHIFT: begin
                if (cs_s) state_nx = ST_COMMIT;        // T_RELEASE
            end
            ST_COMMIT: begin
                if (!cs_s) state_nx = ST_SHIFT;        // T_RESELECT
                else       state_nx = ST_IDLE;         // T_DONE
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        wr_addr = chain[FRAME_W-1 -: ADDR_W];
        wr_data = chain[DATA_W-1:0];
        sdo     = chain[CHAIN_W-1];
        unique case (state)
            ST_COMMIT: wr_stb = 1'b1;
            ST_IDLE,
            ST_SHIFT:  wr_stb = 1'b0;
            default:   wr_stb = 1'b0;
        endcase
    end

endmodule

// File: rtl/qdac_reg_bank.sv
module qdac_reg_bank #(
    parameter  int CHANNELS = 4,
    parameter  int DATA_W   = 16,
    parameter  int ADDR_W   = 2,
    localparam int BUS_W    = CHANNELS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rst_code,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ld_s,
    input  logic              ld_n_raw,
    output logic [BUS_W-1:0]  in_flat,
    output logic [BUS_W-1:0]  hold_flat,
    output logic [BUS_W-1:0]  dac_flat
);

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        logic              wr_hit;
        logic [DATA_W-1:0] in_q;
        logic [DATA_W-1:0] hold_q;

        assign wr_hit = wr_stb && (wr_addr == ADDR_W'(ch));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                in_q <= rst_code;
            end else if (wr_hit) begin
                in_q <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_q <= rst_code;
            end else if (!ld_s) begin
                hold_q <= in_q;
            end
        end

        // The raw strobe opens the path at once; the held copy catches up.
        assign dac_flat [ch*DATA_W +: DATA_W] = ld_n_raw ? hold_q : in_q;
        assign in_flat  [ch*DATA_W +: DATA_W] = in_q;
        assign hold_flat[ch*DATA_W +: DATA_W] = hold_q;
    end

endmodule

// File: rtl/quad_dbuf_serial_if.sv
module quad_dbuf_serial_if #(
    parameter  int CHANNELS = 4,
    parameter  int DATA_W   = 16,
    localparam int ADDR_W   = $clog2(CHANNELS),
    localparam int BUS_W    = CHANNELS * DATA_W
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic              ld_n,
    input  logic              rs_n,
    input  logic              rs_mid,
    output logic              sdo,
    output logic [BUS_W-1:0]  dac_q,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr
);

    localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

    logic              rst_n;
    logic [DATA_W-1:0] rst_code;
    logic [3:0]        sync_q;
    logic              sclk_s;
    logic              cs_s;
    logic              sdi_s;
    logic              ld_s;
    logic [DATA_W-1:0] wr_data;
    logic [BUS_W-1:0]  in_flat;
    logic [BUS_W-1:0]  hold_flat;

    assign rst_n    = por_n & rs_n;
    assign rst_code = (por_n && rs_mid) ? MID_CODE : '0;

    qdac_sync #(
        .WIDTH   (4),
        .RST_VAL (4'b0110)
    ) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     ({sdi, ld_n, cs_n, sclk}),
        .q     (sync_q)
    );

    assign sclk_s = sync_q[0];
    assign cs_s   = sync_q[1];
    assign ld_s   = sync_q[2];
    assign sdi_s  = sync_q[3];

    qdac_serial_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .cs_s    (cs_s),
        .sdi_s   (sdi_s),
        .sdo     (sdo),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    qdac_reg_bank #(
        .CHANNELS (CHANNELS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_code  (rst_code),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ld_s      (ld_s),
        .ld_n_raw  (ld_n),
        .in_flat   (in_flat),
        .hold_flat (hold_flat),
        .dac_flat  (dac_q)
    );

endmodule

// File: rtl/qdac_chk.sv
module qdac_chk #(
    parameter  int CHANNELS = 4,
    parameter  int DATA_W   = 16,
    localparam int BUS_W    = CHANNELS * DATA_W
) (
    input logic             clk,
    input logic             por_n,
    input logic             cs_n,
    input logic             ld_n,
    input logic             rs_n,
    input logic             rs_mid,
    input logic             sdo,
    input logic             wr_stb,
    input logic [BUS_W-1:0] dac_q,
    input logic [BUS_W-1:0] in_flat,
    input logic [BUS_W-1:0] hold_flat
);

    logic [2:0] ld_hi_cnt;
    logic [2:0] ld_lo_cnt;
    logic [2:0] rs_hi_cnt;
    logic [2:0] cs_hi_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ld_hi_cnt <= '0;
            ld_lo_cnt <= '0;
            rs_hi_cnt <= '0;
            cs_hi_cnt <= '0;
        end else begin
            ld_hi_cnt <= !ld_n ? 3'd0 : (ld_hi_cnt == 3'd7 ? ld_hi_cnt : ld_hi_cnt + 3'd1);
            ld_lo_cnt <=  ld_n ? 3'd0 : (ld_lo_cnt == 3'd7 ? ld_lo_cnt : ld_lo_cnt + 3'd1);
            rs_hi_cnt <= !rs_n ? 3'd0 : (rs_hi_cnt == 3'd7 ? rs_hi_cnt : rs_hi_cnt + 3'd1);
            cs_hi_cnt <= !cs_n ? 3'd0 : (cs_hi_cnt == 3'd7 ? cs_hi_cnt : cs_hi_cnt + 3'd1);
        end
    end

    p_stb_pulse_r3: assert property (@(posedge clk) disable iff (!por_n)
        wr_stb |=> !wr_stb);

    p_dac_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
        (ld_n && ld_hi_cnt >= 3'd4 && rs_n && rs_hi_cnt >= 3'd2) |-> $stable(dac_q));

    p_follow_r5: assert property (@(posedge clk) disable iff (!por_n)
        (!ld_n && ld_lo_cnt >= 3'd3 && rs_n && rs_hi_cnt >= 3'd2) |-> (hold_flat == $past(in_flat)));

    p_reset_code_r6: assert property (@(posedge clk) disable iff (!por_n)
        !rs_n |-> (dac_q == {CHANNELS{rs_mid ? (DATA_W'(1) << (DATA_W - 1)) : DATA_W'(0)}}));

    p_sdo_quiet_r2: assert property (@(posedge clk) disable iff (!por_n)
        (cs_n && cs_hi_cnt >= 3'd3 && rs_n && rs_hi_cnt >= 3'd1) |-> $stable(sdo));

endmodule

bind quad_dbuf_serial_if qdac_chk #(
    .CHANNELS (CHANNELS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .cs_n      (cs_n),
    .ld_n      (ld_n),
    .rs_n      (rs_n),
    .rs_mid    (rs_mid),
    .sdo       (sdo),
    .wr_stb    (wr_stb),
    .dac_q     (dac_q),
    .in_flat   (in_flat),
    .hold_flat (hold_flat)
);

// File: tb/sim_quad_dbuf_serial_if.sv
module sim_quad_dbuf_serial_if;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdi = 1'b0;
    logic        ld_n = 1'b1;
    logic        rs_n = 1'b1;
    logic        rs_mid = 1'b0;
    logic        sdo;
    logic [63:0] dac_q;
    logic        wr_stb;
    logic [1:0]  wr_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] exp_in  [4];
    logic [15:0] exp_dac [4];
    logic        hist [0:4095];
    int          n_bits = 0;
    int          stb_cnt = 0;
    logic [1:0]  last_addr = 2'd0;

    always #4 clk = ~clk;

    quad_dbuf_serial_if u0 (
        .clk     (clk),
        .por_n   (por_n),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .sdi     (sdi),
        .ld_n    (ld_n),
        .rs_n    (rs_n),
        .rs_mid  (rs_mid),
        .sdo     (sdo),
        .dac_q   (dac_q),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr)
    );

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt   = stb_cnt + 1;
            last_addr = wr_addr;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pack_exp(input bit use_in);
        logic [63:0] v;
        for (int c = 0; c < 4; c++) v[c*16 +: 16] = use_in ? exp_in[c] : exp_dac[c];
        return v;
    endfunction

    function automatic logic exp_sdo();
        return (n_bits >= 19) ? hist[n_bits - 19] : 1'b0;
    endfunction

    function automatic logic [17:0] last_frame();
        logic [17:0] f;
        for (int j = 0; j < 18; j++) begin
            int idx = n_bits - 18 + j;
            f[17 - j] = (idx >= 0) ? hist[idx] : 1'b0;
        end
        return f;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift nb bits, MSB first; sdo checked after every pulse (R8).
    task automatic shift_bits(input int nb, input logic [31:0] bits);
        cs_n = 1'b0;
        wait_cyc(6);
        for (int i = 0; i < nb; i++) begin
            sdi = bits[nb-1-i];
            wait_cyc(6);
            sclk = 1'b1;
            hist[n_bits] = bits[nb-1-i];
            n_bits++;
            wait_cyc(6);
            check("R8 sdo delay", {63'd0, sdo}, {63'd0, exp_sdo()});
            sclk = 1'b0;
        end
        wait_cyc(6);
    endtask

    // Release select and check the write strobe and the registers (R3, R4, R5).
    task automatic release_cs(input string req);
        int          s0 = stb_cnt;
        logic [17:0] f  = last_frame();
        cs_n = 1'b1;
        wait_cyc(8);
        exp_in[f[17:16]] = f[15:0];
        if (!ld_n) for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
        check({req, " R3 one strobe"}, 64'(stb_cnt - s0), 64'd1);
        check({req, " R3 wr_addr"}, {62'd0, last_addr}, {62'd0, f[17:16]});
        check({req, " R4/R5 dac_q"}, dac_q, pack_exp(1'b0));
    endtask

    task automatic pulse_load();
        ld_n = 1'b0;
        wait_cyc(1);
        for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
        check("R5 load immediate", dac_q, pack_exp(1'b0));
        wait_cyc(6);
        ld_n = 1'b1;
        wait_cyc(6);
        check("R5 load retained", dac_q, pack_exp(1'b0));
    endtask

    task automatic do_reset(input logic mid);
        logic [15:0] code = mid ? 16'h8000 : 16'h0000;
        rs_mid = mid;
        wait_cyc(1);
        rs_n = 1'b0;
        wait_cyc(3);
        for (int c = 0; c < 4; c++) begin
            exp_in[c]  = code;
            exp_dac[c] = code;
        end
        check("R6 reset code during", dac_q, pack_exp(1'b0));
        rs_n = 1'b1;
        wait_cyc(4);
        n_bits = 0;
        check("R6 reset code after", dac_q, pack_exp(1'b0));
        check("R6 sdo cleared", {63'd0, sdo}, 64'd0);
        ld_n = 1'b0;
        wait_cyc(2);
        check("R6 input regs reset", dac_q, pack_exp(1'b1));
        ld_n = 1'b1;
        wait_cyc(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        for (int c = 0; c < 4; c++) begin
            exp_in[c]  = 16'h0;
            exp_dac[c] = 16'h0;
        end
        wait_cyc(5);
        check("R7 por dac zero", dac_q, 64'd0);
        check("R7 por sdo zero", {63'd0, sdo}, 64'd0);
        por_n = 1'b1;
        wait_cyc(5);
        check("R7 after por", dac_q, 64'd0);

        // R1: each address reaches its own channel; held until load (R4).
        for (int a = 0; a < 4; a++) begin
            shift_bits(18, {14'd0, 2'(a), 16'h1100 + 16'(a * 16'h1111)});
            release_cs("R1 addr walk");
        end
        pulse_load();

        // R2: clocks with select high are ignored.
        sdi = 1'b1;
        for (int i = 0; i < 5; i++) begin
            wait_cyc(6);
            sclk = 1'b1;
            wait_cyc(6);
            sclk = 1'b0;
        end
        wait_cyc(6);
        check("R2 sdo unchanged", {63'd0, sdo}, {63'd0, exp_sdo()});
        check("R2 no strobe", 64'(stb_cnt), 64'd4);
        shift_bits(18, {14'd0, 2'd2, 16'hA5C3});
        release_cs("R2 frame after ignored clocks");
        pulse_load();

        // R5: follow while load strobe held low.
        ld_n = 1'b0;
        wait_cyc(6);
        shift_bits(18, {14'd0, 2'd3, 16'hFFFF});
        release_cs("R5 follow");
        wait_cyc(4);
        ld_n = 1'b1;
        wait_cyc(6);
        check("R5 retained after follow", dac_q, pack_exp(1'b0));

        // R9: long and short frames.
        shift_bits(20, {12'd0, 2'b11, 2'b01, 16'h0F0F});
        release_cs("R9 long frame");
        shift_bits(10, {22'd0, 10'h2B5});
        release_cs("R9 short frame");
        pulse_load();

        // R6: both reset codes, then a frame shorter than 18 after reset (R9).
        do_reset(1'b1);
        shift_bits(5, 32'h1F);
        release_cs("R9 short after reset");
        pulse_load();
        do_reset(1'b0);

        // Random frames with random loads.
        for (int k = 0; k < 30; k++) begin
            logic [1:0]  a = 2'($urandom_range(0, 3));
            logic [15:0] d = 16'($urandom);
            if (k == 3) d = 16'h0000;
            if (k == 4) d = 16'hFFFF;
            shift_bits(18, {14'd0, a, d});
            release_cs("R1 random frame");
            if ($urandom_range(0, 3) == 0) pulse_load();
        end
        pulse_load();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule